// File: doc/BRIEF.md
# Serial Character Receiver with Run-Time Rate Selection

This block recovers 8-bit characters from an asynchronous serial line. The line idles high. Each character is framed by one low start bit and one high stop bit, and its data bits arrive least significant bit first. A 3-bit code selects the bit rate while the block runs. The code maps to a clock divisor, which is computed at elaboration time from the `CLK_HZ` parameter.

The line first passes through a two-stage synchronizer. A controller with four states then follows the frame:
- **IDLE** waits for a high-to-low transition on the synchronized line. On that transition it captures the divisor for the current rate code and arms a half-bit timer (transition IDLE→START).
- **START** checks the line when the half-bit timer expires. A low line confirms the start bit (START→DATA). A high line means a glitch, and the controller goes back (START→IDLE).
- **DATA** samples one bit each full bit period. After the eighth bit it moves on (DATA→STOP).
- **STOP** samples the stop bit and always returns (STOP→IDLE). A high stop bit raises a one-cycle valid pulse and updates the output byte. A low stop bit raises a one-cycle framing-error pulse instead.

Top module: `uart_baud_rx`

## Requirements
- R1: Rate codes 0 to 7 select 9600, 14400, 19200, 38400, 57600, 115200, 128000 and 256000 baud. The bit period in clock cycles is round(CLK_HZ / rate).
- R2: A falling edge starts start-bit qualification. If the line is high again half a bit period later, the event is discarded: no valid pulse and no error pulse.
- R3: After a confirmed start, 8 data bits are sampled one bit period apart from the start-bit midpoint. The first bit received lands in `rx_data[0]`.
- R4: If the stop bit is high, `rx_valid` is high for exactly one clock cycle and `rx_data` shows the received byte in that same cycle.
- R5: If the stop bit is low, `rx_ferr` is high for exactly one cycle, `rx_valid` stays low and `rx_data` is unchanged. The two pulses are never high together.
- R6: `rx_data` changes only in a cycle where `rx_valid` is high, and it holds its value between characters.
- R7: While `rst` is high, the controller goes to IDLE, and `rx_valid`, `rx_ferr` and `rx_data` are all 0.
- R8: The rate code is captured at the falling edge that starts a character. Changing `rate_sel` later in that character does not affect how it is received.
- R9: A line held low after a frame does not start a new character. Only a fresh high-to-low transition does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high synchronous reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rate_sel | input | 3 | Bit rate code (see R1) |
| rx_data | output | 8 | Last byte received with a good stop bit |
| rx_valid | output | 1 | One-cycle pulse: new byte on rx_data |
| rx_ferr | output | 1 | One-cycle pulse: stop bit was low |

## Verification
Characters are sent at all eight rate codes. The patterns 0x55, 0xAA, 0x01, 0x80, 0x00, 0xFF and 0xA5 expose bit order and per-bit sampling errors, and the shortest bit period at code 7 stresses timing at half a period. A low pulse shorter than half a bit tests start qualification. A frame with a low stop bit, followed by a line held low, separates framing-error reporting from data hold and from false re-triggering. A rate code changed right after the start bit confirms that the divisor stays locked for the whole character.

// File: rtl/uart_baud_rx_pkg.sv
package uart_baud_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_e;

    localparam int RATE_CODES = 8;

    function automatic int rate_of(input int code);
        case (code)
            0:       return 9600;
            1:       return 14400;
            2:       return 19200;
            3:       return 38400;
            4:       return 57600;
            5:       return 115200;
            6:       return 128000;
            default: return 256000;
        endcase
    endfunction

    function automatic int divisor_of(input int clk_hz, input int code);
        return (clk_hz + rate_of(code) / 2) / rate_of(code);
    endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] q;

    always_ff @(posedge clk) begin
        if (rst) q <= {STAGES{RESET_VAL}};
        else     q <= {q[STAGES-2:0], din};
    end

    assign dout = q[STAGES-1];
endmodule

// File: rtl/rx_rate_table.sv
module rx_rate_table
    import uart_baud_rx_pkg::*;
#(
    parameter int CLK_HZ = 100_000_000,
    parameter int CNT_W  = 14
) (
    input  logic [2:0]       sel,
    output logic [CNT_W-1:0] div
);
    logic [CNT_W-1:0] tbl [RATE_CODES];

    for (genvar g = 0; g < RATE_CODES; g++) begin : g_rate
        assign tbl[g] = CNT_W'(divisor_of(CLK_HZ, g));
    end

    assign div = tbl[sel];
endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             tick
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign tick = (cnt == '0);
endmodule

// File: rtl/uart_baud_rx.sv
module uart_baud_rx
    import uart_baud_rx_pkg::*;
#(
    parameter int CLK_HZ    = 100_000_000,
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rx_line,
    input  logic [2:0]           rate_sel,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_valid,
    output logic                 rx_ferr
);
    localparam int MAX_DIV = divisor_of(CLK_HZ, 0);
    localparam int CNT_W   = $clog2(MAX_DIV + 1);
    localparam int IDX_W   = $clog2(DATA_BITS);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_BITS - 1);

    rx_state_e              state, nxt;
    logic                   s_rx, s_prev, fall;
    logic [CNT_W-1:0]       div_sel, div_q, tmr_val;
    logic                   tmr_load, tick;
    logic [IDX_W-1:0]       bit_idx;
    logic [DATA_BITS-1:0]   shreg;

    rx_sync #(.STAGES(2), .RESET_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (rx_line),
        .dout(s_rx)
    );

    rx_rate_table #(.CLK_HZ(CLK_HZ), .CNT_W(CNT_W)) u_rates (
        .sel(rate_sel),
        .div(div_sel)
    );

    rx_bit_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .load_val(tmr_val),
        .tick    (tick)
    );

    assign fall = s_prev & ~s_rx;

    // next state and timer control
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_IDLE: begin
                if (fall) begin
                    nxt      = ST_START;
                    tmr_load = 1'b1;
                    tmr_val  = (div_sel >> 1) - ONE;
                end
            end
            ST_START: begin
                if (tick) begin
                    if (!s_rx) begin
                        nxt      = ST_DATA;
                        tmr_load = 1'b1;
                        tmr_val  = div_q - ONE;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
            end
            ST_DATA: begin
                if (tick) begin
                    tmr_load = 1'b1;
                    tmr_val  = div_q - ONE;
                    if (bit_idx == LAST_IDX) nxt = ST_STOP;
                end
            end
            ST_STOP: begin
                if (tick) nxt = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            s_prev   <= 1'b1;
            div_q    <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
            rx_ferr  <= 1'b0;
        end else begin
            s_prev   <= s_rx;
            rx_valid <= 1'b0;
            rx_ferr  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (fall) begin
                        div_q   <= div_sel;
                        bit_idx <= '0;
                    end
                end
                ST_START: ;
                ST_DATA: begin
                    if (tick) begin
                        shreg   <= {s_rx, shreg[DATA_BITS-1:1]};
                        bit_idx <= bit_idx + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (tick) begin
                        if (s_rx) begin
                            rx_valid <= 1'b1;
                            rx_data  <= shreg;
                        end else begin
                            rx_ferr  <= 1'b1;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/uart_baud_rx_sva.sv
module uart_baud_rx_sva
    import uart_baud_rx_pkg::*;
#(
    parameter int CNT_W     = 14,
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 rx_valid,
    input logic                 rx_ferr,
    input logic [DATA_BITS-1:0] rx_data,
    input rx_state_e            state,
    input logic [CNT_W-1:0]     div_q
);
    assert_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        !(rx_valid && rx_ferr));

    assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    assert_ferr_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        rx_ferr |=> !rx_ferr);

    assert_data_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_data) |-> rx_valid);

    assert_end_of_frame_R3: assert property (@(posedge clk) disable iff (rst)
        (rx_valid || rx_ferr) |-> ($past(state) == ST_STOP && state == ST_IDLE));

    assert_rate_locked_R8: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(div_q));

    assert_reset_state_R7: assert property (@(posedge clk)
        rst |=> (state == ST_IDLE && !rx_valid && !rx_ferr && rx_data == '0));
endmodule

bind uart_baud_rx uart_baud_rx_sva #(.CNT_W(CNT_W), .DATA_BITS(DATA_BITS)) u_sva (
    .clk     (clk),
    .rst     (rst),
    .rx_valid(rx_valid),
    .rx_ferr (rx_ferr),
    .rx_data (rx_data),
    .state   (state),
    .div_q   (div_q)
);

// File: tb/uart_baud_rx_test.sv
`timescale 1ns/1ps
module uart_baud_rx_test;
    localparam int BCLK = 3_840_000;

    typedef struct {
        logic [7:0] d;
        bit         err;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_line = 1'b1;
    logic [2:0] rate_sel = 3'd0;
    logic [7:0] rx_data;
    logic       rx_valid, rx_ferr;

    int checks = 0, errors = 0, events = 0, pushed = 0;
    logic [7:0] last_good = 8'h00;
    exp_t q[$];
    bit done = 0;

    always #2 clk = ~clk;

    uart_baud_rx #(.CLK_HZ(BCLK)) uut (
        .clk(clk), .rst(rst), .rx_line(rx_line), .rate_sel(rate_sel),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ferr(rx_ferr)
    );

    function automatic int bdiv(input int code);
        int rates[8] = '{9600, 14400, 19200, 38400, 57600, 115200, 128000, 256000};
        return (BCLK + rates[code] / 2) / rates[code];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive_bit(input logic b, input int div);
        rx_line = b;
        repeat (div) @(negedge clk);
    endtask

    // driver: pushes the expected item, then drives one frame
    task automatic send_frame(input logic [7:0] d, input bit stop_hi, input int code,
                              input int switch_code, input int hold_low, input string req);
        int div;
        exp_t e;
        div = bdiv(code);
        rate_sel = 3'(code);
        e.d   = stop_hi ? d : last_good;
        e.err = !stop_hi;
        e.req = req;
        q.push_back(e);
        pushed++;
        if (stop_hi) last_good = d;
        drive_bit(1'b0, div);
        if (switch_code >= 0) rate_sel = 3'(switch_code);
        for (int i = 0; i < 8; i++) drive_bit(d[i], div);
        drive_bit(stop_hi, div);
        if (hold_low > 0) drive_bit(1'b0, hold_low);
        drive_bit(1'b1, div);
    endtask

    // monitor: compares each completed character against the scoreboard
    initial begin
        bit was_event = 0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (was_event)
                    check(!rx_valid && !rx_ferr, "R4", "pulse longer than one cycle",
                          {rx_valid, rx_ferr}, 0);
                was_event = 0;
                if (rx_valid || rx_ferr) begin
                    exp_t e;
                    events++;
                    was_event = 1;
                    check(!(rx_valid && rx_ferr), "R5", "valid and ferr together",
                          {rx_valid, rx_ferr}, 0);
                    if (q.size() == 0) begin
                        check(0, "R2", "unexpected character event", rx_data, 0);
                    end else begin
                        e = q.pop_front();
                        check(rx_ferr == e.err, e.req, "framing error flag", rx_ferr, e.err);
                        check(rx_data == e.d, e.req, "received byte", rx_data, e.d);
                    end
                end
            end
        end
    end

    initial begin
        repeat (190_000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int ev0;
        repeat (5) @(negedge clk);
        check(!rx_valid && !rx_ferr && rx_data == 8'h00, "R7", "reset outputs",
              {rx_valid, rx_ferr, rx_data}, 0);
        rst = 1'b0;
        repeat (10) @(negedge clk);

        // R1 / R3: every rate code, varied patterns
        send_frame(8'h55, 1, 0, -1, 0, "R1");
        send_frame(8'hAA, 1, 1, -1, 0, "R1");
        send_frame(8'h01, 1, 2, -1, 0, "R3");
        send_frame(8'h80, 1, 3, -1, 0, "R3");
        send_frame(8'h00, 1, 4, -1, 0, "R1");
        send_frame(8'hFF, 1, 5, -1, 0, "R1");
        send_frame(8'hA5, 1, 6, -1, 0, "R3");
        send_frame(8'h3C, 1, 7, -1, 0, "R1");
        send_frame(8'hC3, 1, 7, -1, 0, "R3");

        // R2: short low glitch is discarded
        ev0 = events;
        rate_sel = 3'd0;
        drive_bit(1'b0, bdiv(0) / 4);
        drive_bit(1'b1, 3 * bdiv(0));
        check(events == ev0, "R2", "glitch produced an event", events, ev0);
        check(rx_data == last_good, "R6", "data after glitch", rx_data, last_good);
        send_frame(8'h96, 1, 2, -1, 0, "R2");

        // R5 / R9: low stop bit, then line held low
        ev0 = events;
        send_frame(8'h5A, 0, 3, -1, 3 * bdiv(3), "R5");
        check(events == ev0 + 1, "R9", "held-low line retriggered", events, ev0 + 1);
        check(rx_data == 8'h96, "R6", "data held after framing error", rx_data, 8'h96);

        // R8: rate code changed after the start bit
        send_frame(8'h69, 1, 4, 0, 0, "R8");
        send_frame(8'hE1, 1, 0, 7, 0, "R8");

        // back-to-back frames with short gap
        send_frame(8'h12, 1, 6, -1, 0, "R4");
        send_frame(8'h34, 1, 6, -1, 0, "R4");

        repeat (100) @(negedge clk);
        check(q.size() == 0, "R4", "expected characters not produced", q.size(), 0);
        check(events == pushed, "R4", "event count", events, pushed);
        check(rx_data == 8'h34, "R6", "final held byte", rx_data, 8'h34);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule